// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits behind a serial flash command decoder. It accepts program and erase requests that have already been decoded, checks each against the write-enable latch and the busy state, and aligns the request address to the granularity the operation needs. An accepted operation then sweeps a behavioural byte array one byte per cycle. After the sweep, a configurable busy period stands in for the cell algorithm. A status byte is always visible on its own port, so software-facing logic can poll the write-in-progress bit while the operation runs. A one-cycle read port returns array contents.

Erase sets every byte of its region to 0xFF. There are three erase sizes: a sector, a block, and the whole array. Programming can only clear bits. It writes 1 to `2^PAGE_W` bytes inside a single page and wraps at the page end. The defaults are scaled down so the array stays small: 1 KiB array, 16-byte page, 64-byte sector, 256-byte block. Setting `PAGE_W=8`, `SECTOR_W=12`, `BLOCK_W=16` gives the production geometry of 256 B, 4 KiB and 64 KiB.

Top module: `fpe_seq`

## Requirements
- R1: `status` bit 0 is write-in-progress (WIP), bit 1 is the write-enable latch (WEL), and bits 7:2 read 0. After reset `status` is 0x00. During an operation it reads 0x03.
- R2: Request codes are carried on `req_op` with `req_valid` high, and are accepted only while idle: 1 sets WEL, 2 clears WEL, 3 programs, 4 sector erase, 5 block erase, 6 chip erase. Codes 0 and 7 do nothing. A WEL change is visible in `status` at the next cycle.
- R3: A program or erase request while WEL is 0 is ignored. WIP stays 0 and the array is unchanged.
- R4: Sector erase sets to 0xFF every byte of the `2^SECTOR_W`-aligned region that holds `req_addr`. All other bytes are unchanged.
- R5: Block erase sets to 0xFF every byte of the `2^BLOCK_W`-aligned region that holds `req_addr`. All other bytes are unchanged.
- R6: Chip erase sets every array byte to 0xFF.
- R7: Program writes `req_len`+1 bytes. Byte i is `req_data[8*i+7:8*i]`. The new value is the old value ANDed with the data byte.
- R8: A program that runs past the end of a page wraps to the start of the same page. Byte i lands at page offset (`req_addr` offset + i) mod `2^PAGE_W`.
- R9: WIP rises at the cycle after acceptance. It stays high for exactly N + `BUSY_CYC` cycles, where N is the number of bytes the operation touches.
- R10: Every request presented while WIP is high is ignored, including a request in the last busy cycle. A request in the first cycle with WIP low is accepted.
- R11: WEL clears in the same cycle that WIP falls.
- R12: `rd_data` returns the array byte at `rd_addr` one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 3 | Request code |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | PAGE_W | Program byte count minus one |
| req_data | input | 8*2^PAGE_W | Program data; byte i in bits 8i+7:8i |
| status | output | 8 | Status byte: WIP in bit 0, WEL in bit 1 |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte, one cycle latency |

## Verification
Two functions can fall in the same cycle: completion of an operation and arrival of a new request. The bench counts busy cycles while polling WIP. It drives a write-enable request into the exact last cycle in which WIP still reads 1, then checks that WEL is 0 after completion. It then issues the same request in the next cycle and checks that it takes effect. Requests earlier in the busy window are also checked: they must not change the status byte or touch the array, as seen through the read port.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_WREN   = 3'd1,
        OP_WRDI   = 3'd2,
        OP_PROG   = 3'd3,
        OP_SERASE = 3'd4,
        OP_BERASE = 3'd5,
        OP_CERASE = 3'd6,
        OP_RSVD   = 3'd7
    } fpe_op_e;

    typedef enum logic [1:0] {
        K_PROG,
        K_SEC,
        K_BLK,
        K_CHIP
    } fpe_kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SWEEP,
        S_WAIT
    } fpe_state_e;

endpackage

// File: rtl/fpe_req_check.sv
module fpe_req_check
    import fpe_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PAGE_W   = 4,
    parameter int SECTOR_W = 6,
    parameter int BLOCK_W  = 8
) (
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PAGE_W-1:0] req_len,
    input  logic              idle,
    input  logic              wel,
    output logic              start,
    output logic              set_wel,
    output logic              clr_wel,
    output fpe_kind_e         kind,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] last
);

    localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} >> (ADDR_W - SECTOR_W);
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} >> (ADDR_W - BLOCK_W);

    logic    go;
    fpe_op_e op;

    always_comb begin
        op      = fpe_op_e'(req_op);
        go      = req_valid && idle;
        set_wel = go && (op == OP_WREN);
        clr_wel = go && (op == OP_WRDI);
        start   = 1'b0;
        kind    = K_PROG;
        base    = req_addr;
        last    = '0;
        case (op)
            OP_PROG: begin
                start = go && wel;
                kind  = K_PROG;
                base  = req_addr;
                last  = {{(ADDR_W-PAGE_W){1'b0}}, req_len};
            end
            OP_SERASE: begin
                start = go && wel;
                kind  = K_SEC;
                base  = req_addr & ~SEC_MASK;
                last  = SEC_MASK;
            end
            OP_BERASE: begin
                start = go && wel;
                kind  = K_BLK;
                base  = req_addr & ~BLK_MASK;
                last  = BLK_MASK;
            end
            OP_CERASE: begin
                start = go && wel;
                kind  = K_CHIP;
                base  = '0;
                last  = {ADDR_W{1'b1}};
            end
            default: begin
                start = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fpe_timer.sv
module fpe_timer #(
    parameter int BUSY_CYC = 8,
    localparam int CNT_W   = $clog2(BUSY_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d     = t_q;
        expired = t_q.run && (t_q.cnt == '0);
        if (load) begin
            t_d.run = 1'b1;
            t_d.cnt = CNT_W'(BUSY_CYC - 1);
        end else if (expired) begin
            t_d.run = 1'b0;
        end else if (t_q.run) begin
            t_d.cnt = t_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    AST_TMR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.run && t_q.cnt == '0 && !load) |=> !t_q.run); // R9

    AST_TMR_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!t_q.run && !load) |=> !t_q.run); // R9

endmodule

// File: rtl/fpe_array.sv
module fpe_array #(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [7:0]        peek_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] mem [DEPTH];
    logic [7:0] rd_d, rd_q;

    always_comb begin
        peek_data = mem[peek_addr];
        rd_d      = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/fpe_seq.sv
module fpe_seq
    import fpe_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int PAGE_W   = 4,
    parameter int SECTOR_W = 6,
    parameter int BLOCK_W  = 8,
    parameter int BUSY_CYC = 8,
    localparam int PAGE_BYTES = 1 << PAGE_W,
    localparam int DATA_W     = 8 * PAGE_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [PAGE_W-1:0] req_len,
    input  logic [DATA_W-1:0] req_data,
    output logic [7:0]        status,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam logic [ADDR_W-1:0] SEC_MASK = {ADDR_W{1'b1}} >> (ADDR_W - SECTOR_W);
    localparam logic [ADDR_W-1:0] BLK_MASK = {ADDR_W{1'b1}} >> (ADDR_W - BLOCK_W);

    typedef struct packed {
        fpe_state_e        st;
        fpe_kind_e         kind;
        logic [ADDR_W-1:0] ptr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] last;
        logic [DATA_W-1:0] data;
        logic              wel;
    } seq_t;

    seq_t r_d, r_q;

    logic              ck_start, ck_set_wel, ck_clr_wel;
    fpe_kind_e         ck_kind;
    logic [ADDR_W-1:0] ck_base, ck_last;
    logic              tmr_load, tmr_expired;
    logic              wr_en;
    logic [ADDR_W-1:0] sweep_addr;
    logic [7:0]        old_byte, new_byte, src_byte;
    logic              wip;

    fpe_req_check #(
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W),
        .SECTOR_W (SECTOR_W),
        .BLOCK_W  (BLOCK_W)
    ) u_check (
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_len   (req_len),
        .idle      (r_q.st == S_IDLE),
        .wel       (r_q.wel),
        .start     (ck_start),
        .set_wel   (ck_set_wel),
        .clr_wel   (ck_clr_wel),
        .kind      (ck_kind),
        .base      (ck_base),
        .last      (ck_last)
    );

    fpe_timer #(
        .BUSY_CYC (BUSY_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    fpe_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (sweep_addr),
        .wr_data   (new_byte),
        .peek_addr (sweep_addr),
        .peek_data (old_byte),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always_comb begin
        r_d      = r_q;
        wr_en    = 1'b0;
        tmr_load = 1'b0;

        if (r_q.kind == K_PROG) begin
            sweep_addr = {r_q.base[ADDR_W-1:PAGE_W],
                          r_q.base[PAGE_W-1:0] + r_q.ptr[PAGE_W-1:0]};
        end else begin
            sweep_addr = r_q.base | r_q.ptr;
        end
        src_byte = r_q.data[8*r_q.ptr[PAGE_W-1:0] +: 8];
        new_byte = (r_q.kind == K_PROG) ? (old_byte & src_byte) : 8'hFF;

        case (r_q.st)
            S_IDLE: begin
                if (ck_set_wel) r_d.wel = 1'b1;
                if (ck_clr_wel) r_d.wel = 1'b0;
                if (ck_start) begin
                    r_d.st   = S_SWEEP;
                    r_d.kind = ck_kind;
                    r_d.ptr  = '0;
                    r_d.base = ck_base;
                    r_d.last = ck_last;
                    r_d.data = req_data;
                end
            end
            S_SWEEP: begin
                wr_en = 1'b1;
                if (r_q.ptr == r_q.last) begin
                    r_d.st   = S_WAIT;
                    tmr_load = 1'b1;
                end else begin
                    r_d.ptr = r_q.ptr + 1'b1;
                end
            end
            S_WAIT: begin
                if (tmr_expired) begin
                    r_d.st  = S_IDLE;
                    r_d.wel = 1'b0;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.kind <= K_PROG;
        end else begin
            r_q <= r_d;
        end
    end

    assign wip    = (r_q.st != S_IDLE);
    assign status = {6'b0, r_q.wel, wip};

    AST_BUSY_HAS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> r_q.wel); // R3

    AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(r_q.wel)); // R3

    AST_END_CLEARS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> !r_q.wel); // R11

    AST_BUSY_HOLDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> ($stable(r_q.base) && $stable(r_q.last) && $stable(r_q.kind))); // R10

    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && r_q.kind == K_PROG) |->
            (sweep_addr[ADDR_W-1:PAGE_W] == r_q.base[ADDR_W-1:PAGE_W])); // R8

    AST_SECTOR_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && r_q.kind == K_SEC) |-> ((sweep_addr & ~SEC_MASK) == r_q.base)); // R4

    AST_BLOCK_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && r_q.kind == K_BLK) |-> ((sweep_addr & ~BLK_MASK) == r_q.base)); // R5

    AST_ERASE_WRITES_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && r_q.kind != K_PROG) |-> (new_byte == 8'hFF)); // R6

endmodule

// File: tb/sim_fpe_seq.sv
module sim_fpe_seq;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 10;
    localparam int PAGE_W     = 4;
    localparam int SECTOR_W   = 6;
    localparam int BLOCK_W    = 8;
    localparam int BUSY_CYC   = 8;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DATA_W     = 8 * PAGE_BYTES;

    localparam logic [2:0] C_WREN = 3'd1, C_WRDI = 3'd2, C_PROG = 3'd3,
                           C_SER  = 3'd4, C_BER  = 3'd5, C_CER  = 3'd6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [PAGE_W-1:0] req_len = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [7:0]        status;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;

    logic [7:0] model [DEPTH];
    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpe_seq #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W),
        .BLOCK_W(BLOCK_W), .BUSY_CYC(BUSY_CYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_len(req_len), .req_data(req_data),
        .status(status), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input int addr, input int len,
                         input logic [DATA_W-1:0] data);
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = ADDR_W'(addr);
        req_len   = PAGE_W'(len);
        req_data  = data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_busy(input string req, input int exp_cycles);
        int cnt = 0;
        while (status[0] && cnt < 5000) begin
            check({req, " status while busy"}, status, 8'h03);
            cnt++;
            @(negedge clk);
        end
        check({req, " busy length"}, cnt, exp_cycles);
        check("R11 status after completion", status, 8'h00);
    endtask

    task automatic compare_array(input string req);
        int bad = 0;
        for (int a = 0; a < DEPTH; a++) begin
            rd_addr = ADDR_W'(a);
            @(negedge clk);
            if (rd_data !== model[a]) begin
                if (bad < 4)
                    $display("FAIL %s byte 0x%0h actual=0x%0h expected=0x%0h",
                             req, a, rd_data, model[a]);
                bad++;
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    function automatic logic [DATA_W-1:0] pattern(input int seed);
        logic [DATA_W-1:0] d;
        for (int i = 0; i < PAGE_BYTES; i++)
            d[8*i +: 8] = 8'((seed * 29 + i * 53) ^ (i << 3) ^ 8'hA5);
        return d;
    endfunction

    function automatic void model_prog(input int addr, input int len,
                                       input logic [DATA_W-1:0] d);
        for (int i = 0; i <= len; i++) begin
            int a;
            a = (addr & ~(PAGE_BYTES - 1)) | ((addr + i) & (PAGE_BYTES - 1));
            model[a] = model[a] & d[8*i +: 8];
        end
    endfunction

    function automatic void model_erase(input int addr, input int w);
        int b;
        b = addr & ~((1 << w) - 1);
        for (int i = 0; i < (1 << w); i++) model[b + i] = 8'hFF;
    endfunction

    task automatic t_reset;
        check("R1 reset status", status, 8'h00);
        rd_addr = '0;
        @(negedge clk);
        check("R12 read port after reset idle", status[0], 0);
    endtask

    task automatic t_chip_erase;
        issue(C_WREN, 0, 0, '0);
        check("R2 write enable sets WEL", status, 8'h02);
        issue(C_CER, 0, 0, '0);
        wait_busy("R6 R9 chip erase", DEPTH + BUSY_CYC);
        for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
        compare_array("R6 chip erase contents");
    endtask

    task automatic t_wel_gate;
        issue(C_WREN, 0, 0, '0);
        issue(C_WRDI, 0, 0, '0);
        check("R2 write disable clears WEL", status, 8'h00);
        issue(3'd0, 0, 0, '0);
        issue(3'd7, 0, 0, '0);
        check("R2 codes 0 and 7 no effect", status, 8'h00);
        issue(C_PROG, 12'h040, 7, '0);
        check("R3 program without WEL ignored", status, 8'h00);
        issue(C_SER, 12'h100, 0, '0);
        check("R3 erase without WEL ignored", status, 8'h00);
        repeat (3) @(negedge clk);
        check("R3 still idle", status, 8'h00);
    endtask

    task automatic t_program;
        logic [DATA_W-1:0] d1, d2;
        d1 = pattern(1);
        d2 = pattern(7);
        issue(C_WREN, 0, 0, '0);
        issue(C_PROG, 12'h123, 4, d1);
        wait_busy("R7 R9 program 5 bytes", 5 + BUSY_CYC);
        model_prog(12'h123, 4, d1);
        issue(C_WREN, 0, 0, '0);
        issue(C_PROG, 12'h121, 5, d2);
        wait_busy("R7 R9 overlapping program", 6 + BUSY_CYC);
        model_prog(12'h121, 5, d2);
        issue(C_WREN, 0, 0, '0);
        issue(C_PROG, 12'h3FF, 0, pattern(3));
        wait_busy("R7 single byte program", 1 + BUSY_CYC);
        model_prog(12'h3FF, 0, pattern(3));
        compare_array("R7 program ANDs data");
    endtask

    task automatic t_wrap;
        logic [DATA_W-1:0] d;
        d = pattern(11);
        issue(C_WREN, 0, 0, '0);
        issue(C_PROG, 12'h25E, PAGE_BYTES - 1, d);
        wait_busy("R8 full page from offset 14", PAGE_BYTES + BUSY_CYC);
        model_prog(12'h25E, PAGE_BYTES - 1, d);
        d = pattern(5);
        issue(C_WREN, 0, 0, '0);
        issue(C_PROG, 12'h30D, 6, d);
        wait_busy("R8 partial wrap", 7 + BUSY_CYC);
        model_prog(12'h30D, 6, d);
        compare_array("R8 page wrap contents");
    endtask

    task automatic t_erases;
        issue(C_WREN, 0, 0, '0);
        issue(C_SER, 12'h0A5, 0, '0);
        wait_busy("R4 R9 sector erase", (1 << SECTOR_W) + BUSY_CYC);
        model_erase(12'h0A5, SECTOR_W);
        compare_array("R4 sector erase region");
        issue(C_WREN, 0, 0, '0);
        issue(C_BER, 12'h2F0, 0, '0);
        wait_busy("R5 R9 block erase", (1 << BLOCK_W) + BUSY_CYC);
        model_erase(12'h2F0, BLOCK_W);
        compare_array("R5 block erase region");
    endtask

    task automatic t_busy_collision;
        int cnt = 0;
        int total = (1 << SECTOR_W) + BUSY_CYC;
        issue(C_WREN, 0, 0, '0);
        issue(C_PROG, 12'h3C4, 3, '0);
        wait_busy("R7 zero program", 4 + BUSY_CYC);
        model_prog(12'h3C4, 3, '0);
        issue(C_WREN, 0, 0, '0);
        issue(C_SER, 12'h3C7, 0, '0);
        while (status[0] && cnt < 5000) begin
            cnt++;
            if (cnt == 12)
                check("R10 write disable while busy ignored", status, 8'h03);
            req_valid = 1'b0;
            if (cnt == 10) begin
                req_valid = 1'b1; req_op = C_WRDI;
            end else if (cnt == 20) begin
                req_valid = 1'b1; req_op = C_CER;
            end else if (cnt == 30) begin
                req_valid = 1'b1; req_op = C_PROG; req_addr = 10'h000;
                req_len = 4'd3; req_data = '0;
            end else if (cnt == total) begin
                req_valid = 1'b1; req_op = C_WREN;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check("R9 sector busy length with collisions", cnt, total);
        check("R10 write enable in last busy cycle ignored", status, 8'h00);
        model_erase(12'h3C7, SECTOR_W);
        issue(C_WREN, 0, 0, '0);
        check("R10 write enable right after completion accepted", status, 8'h02);
        issue(C_WRDI, 0, 0, '0);
        check("R2 disable after collision test", status, 8'h00);
        compare_array("R10 busy requests left array untouched");
    endtask

    task automatic t_read_latency;
        rd_addr = 10'h3C4;
        @(negedge clk);
        check("R12 read byte after erase", rd_data, 8'hFF);
        rd_addr = 10'h2F0;
        @(negedge clk);
        check("R12 read erased block byte", rd_data, model[10'h2F0]);
        rd_addr = 10'h3FF;
        @(negedge clk);
        check("R12 read programmed byte", rd_data, model[10'h3FF]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_chip_erase();
        t_wel_gate();
        compare_array("R3 ignored requests left array");
        t_program();
        t_wrap();
        t_erases();
        t_busy_collision();
        t_read_latency();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule